// File: doc/BRIEF.md
# Data Breakpoint and Fault Syndrome Unit

This unit sits beside the load/store completion point of a processor core. For every access that completes, it receives the effective address, the direction (load or store), and two fault flags from an external translation unit: a translation miss and a protection violation. It compares the access address against two programmable breakpoint registers at doubleword granularity. Each register has its own enable for reads and its own enable for writes.

When a breakpoint hit, a translation miss or a protection violation occurs, the unit raises a one-cycle data-storage exception request with the fixed vector offset 0x00300. In the same cycle it latches a 32-bit syndrome word that records the cause and the direction. Software programs the breakpoints through a small register write port, and can overwrite the syndrome through the same port. The unit does no translation, no table walk and no flushing.

Bit numbering in this document is big-endian: bit n of a 32-bit word is the port bit [31-n].

Top module: `dstore_watch`

## Requirements
- R1: After reset, both breakpoint registers are zero, so both read and write enables are off. The syndrome reads 0 and `exc_req` is 0.
- R2: The breakpoint compare uses big-endian bits 0..28 of the address, that is `acc_addr[31:3]` against `bp[31:3]`. Address bits [2:0] are ignored.
- R3: There are two independent breakpoint registers, written at `cfg_sel` 0 and 1. A qualified match against either one is a breakpoint hit.
- R4: Big-endian bit 30 of a breakpoint register (`bp[1]`) enables matches on stores. Big-endian bit 31 (`bp[0]`) enables matches on loads. A match in a direction whose enable is off is no hit.
- R5: Syndrome big-endian bit 9 (`synd_q[22]`) is set when the completing access is a breakpoint hit.
- R6: Syndrome big-endian bit 6 (`synd_q[25]`) is 1 for a store and 0 for a load.
- R7: Syndrome big-endian bit 1 (`synd_q[30]`) follows the translation-miss flag. Big-endian bit 4 (`synd_q[27]`) follows the protection-violation flag.
- R8: `exc_req` is high for exactly the cycle after an `acc_valid` cycle in which a hit, a miss or a protection violation is present, and is low otherwise. `exc_vec` is 0x00300 while `exc_req` is high and 0 otherwise.
- R9: The syndrome is loaded only when an exception is raised, and holds otherwise. Every bit other than 22, 25, 27 and 30 reads 0.
- R10: A write at `cfg_sel` 2 loads `cfg_wdata` masked to the four defined bits into the syndrome. If an exception is raised in the same cycle, the exception's syndrome wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0/1 breakpoint, 2 syndrome |
| cfg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | Access-complete strobe |
| acc_addr | input | 32 | Effective address of the completing access |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_tmiss | input | 1 | Translation not found |
| acc_prot | input | 1 | Protection check denied the access |
| synd_q | output | 32 | Fault syndrome word |
| exc_req | output | 1 | Data-storage exception request pulse |
| exc_vec | output | 20 | Vector offset accompanying the request |

## Verification
The hardest case is an address that matches a breakpoint but is not a hit. This happens when the enable for that direction is off, or when only the ignored low bits line up. A sweep of that kind can look correct even when the direction qualification is swapped. The bench therefore steps through all sixteen read/write enable combinations of both registers. For each one it issues addresses at every low-bit offset inside the watched doubleword and just past it, in both directions and with every fault-flag combination. It also makes a syndrome write and a faulting access collide in the same cycle.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  localparam int WORD_W  = 32;
  localparam int IGN_LSB = 3;               // doubleword granularity
  localparam int VEC_W   = 20;
  localparam logic [VEC_W-1:0] DSTORE_VEC = 20'h00300;

  // big-endian bit number -> port bit index
  function automatic int be_bit(input int n);
    return WORD_W - 1 - n;
  endfunction

  localparam int SYN_MISS  = WORD_W - 1 - 1;
  localparam int SYN_PROT  = WORD_W - 1 - 4;
  localparam int SYN_STORE = WORD_W - 1 - 6;
  localparam int SYN_BKPT  = WORD_W - 1 - 9;
  localparam int BP_WEN    = WORD_W - 1 - 30;
  localparam int BP_REN    = WORD_W - 1 - 31;

  localparam logic [WORD_W-1:0] SYN_MASK =
    (WORD_W'(1) << SYN_MISS) | (WORD_W'(1) << SYN_PROT) |
    (WORD_W'(1) << SYN_STORE) | (WORD_W'(1) << SYN_BKPT);
  localparam logic [WORD_W-1:0] SYN_FAULT =
    (WORD_W'(1) << SYN_MISS) | (WORD_W'(1) << SYN_PROT) |
    (WORD_W'(1) << SYN_BKPT);

  function automatic logic bp_match(input logic [WORD_W-1:0] bp,
                                    input logic [WORD_W-1:0] addr,
                                    input logic store);
    logic same;
    same = (bp[WORD_W-1:IGN_LSB] == addr[WORD_W-1:IGN_LSB]);
    return same && (store ? bp[BP_WEN] : bp[BP_REN]);
  endfunction

  function automatic logic [WORD_W-1:0] make_syn(input logic miss,
                                                 input logic prot,
                                                 input logic store,
                                                 input logic hit);
    logic [WORD_W-1:0] s;
    s = '0;
    s[SYN_MISS]  = miss;
    s[SYN_PROT]  = prot;
    s[SYN_STORE] = store;
    s[SYN_BKPT]  = hit;
    return s;
  endfunction
endpackage

// File: rtl/dsw_bp_reg.sv
module dsw_bp_reg
  import dsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic              acc_valid,
  input  logic [WORD_W-1:0] acc_addr,
  input  logic              acc_store,
  output logic              hit
);
  logic [WORD_W-1:0] bp_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     bp_q <= '0;
    else if (wr_en) bp_q <= wdata;
  end

  assign hit = acc_valid && bp_match(bp_q, acc_addr, acc_store);

  // R4: a store hit needs the write enable, a load hit the read enable
  assert_store_needs_wen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && acc_store) |-> bp_q[BP_WEN]);
  assert_load_needs_ren_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !acc_store) |-> bp_q[BP_REN]);
  // R1: in the first cycle after reset the register is still empty, so no hit
  assert_reset_no_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !hit);
endmodule

// File: rtl/dsw_syndrome.sv
module dsw_syndrome
  import dsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_store,
  input  logic              acc_tmiss,
  input  logic              acc_prot,
  input  logic              bp_hit,
  input  logic              sw_we,
  input  logic [WORD_W-1:0] sw_data,
  output logic [WORD_W-1:0] synd_q,
  output logic              exc_req
);
  logic [WORD_W-1:0] syn_next;
  logic              fire;

  assign syn_next = make_syn(acc_tmiss, acc_prot, acc_store, bp_hit);
  assign fire     = acc_valid && ((syn_next & SYN_FAULT) != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      synd_q  <= '0;
      exc_req <= 1'b0;
    end else begin
      exc_req <= fire;
      if (fire)       synd_q <= syn_next;          // exception wins (R10)
      else if (sw_we) synd_q <= sw_data & SYN_MASK;
    end
  end

  // R9: undefined bits always read zero
  assert_undef_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (synd_q & ~SYN_MASK) == '0);
  // R9: no exception and no software write leaves the syndrome unchanged
  assert_syn_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !sw_we) |=> $stable(synd_q));
  // R8: a request always shows a fault cause in the syndrome
  assert_req_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> ((synd_q & SYN_FAULT) != '0));
endmodule

// File: rtl/dstore_watch.sv
module dstore_watch
  import dsw_pkg::*;
#(
  parameter int NUM_BP = 2,
  parameter int SEL_W  = $clog2(NUM_BP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic [WORD_W-1:0] acc_addr,
  input  logic              acc_store,
  input  logic              acc_tmiss,
  input  logic              acc_prot,
  output logic [WORD_W-1:0] synd_q,
  output logic              exc_req,
  output logic [VEC_W-1:0]  exc_vec
);
  localparam logic [SEL_W-1:0] SYN_SEL = SEL_W'(NUM_BP);

  logic [NUM_BP-1:0] hit_vec;
  logic              bp_hit;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    dsw_bp_reg u_bp (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_we && (cfg_sel == SEL_W'(i))),
      .wdata     (cfg_wdata),
      .acc_valid (acc_valid),
      .acc_addr  (acc_addr),
      .acc_store (acc_store),
      .hit       (hit_vec[i])
    );
  end

  assign bp_hit = |hit_vec;

  dsw_syndrome u_syn (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_store (acc_store),
    .acc_tmiss (acc_tmiss),
    .acc_prot  (acc_prot),
    .bp_hit    (bp_hit),
    .sw_we     (cfg_we && (cfg_sel == SYN_SEL)),
    .sw_data   (cfg_wdata),
    .synd_q    (synd_q),
    .exc_req   (exc_req)
  );

  assign exc_vec = exc_req ? DSTORE_VEC : '0;

  // R8: a request only follows a completing access
  assert_req_after_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $past(acc_valid));
  // R5: a breakpoint hit is recorded in the syndrome on the next cycle
  assert_hit_recorded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bp_hit |=> (exc_req && synd_q[SYN_BKPT]));
  // R6: the direction bit follows the access that raised the request
  assert_dir_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (synd_q[SYN_STORE] == $past(acc_store)));
endmodule

// File: tb/dstore_watch_bench.sv
module dstore_watch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_store = 1'b0, acc_tmiss = 1'b0, acc_prot = 1'b0;
  logic [31:0] synd_q;
  logic        exc_req;
  logic [19:0] exc_vec;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  logic [31:0] bp_m [2];
  logic [31:0] exp_syn;

  always #2 clk = ~clk;

  dstore_watch u_dstore_watch (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_store(acc_store), .acc_tmiss(acc_tmiss), .acc_prot(acc_prot),
    .synd_q(synd_q), .exc_req(exc_req), .exc_vec(exc_vec));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    if (sel < 2) bp_m[sel] = d;
    else exp_syn = d & 32'h4A40_0000;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // expected hit from the requirement text (R2, R4)
  function automatic logic exp_hit(input logic [31:0] a, input logic st);
    logic h = 1'b0;
    for (int i = 0; i < 2; i++)
      if ((a >> 3) == (bp_m[i] >> 3) && (st ? bp_m[i][1] : bp_m[i][0])) h = 1'b1;
    return h;
  endfunction

  task automatic access(input logic [31:0] a, input logic st, input logic mi,
                        input logic pr, input string tag);
    logic h, fire;
    logic [31:0] ns;
    @(negedge clk);
    chk({tag, " R8 request low between accesses"}, 32'(exc_req), 0);
    acc_valid = 1'b1; acc_addr = a; acc_store = st; acc_tmiss = mi; acc_prot = pr;
    h = exp_hit(a, st);
    ns = (32'(mi) << 30) | (32'(pr) << 27) | (32'(st) << 25) | (32'(h) << 22);
    fire = h | mi | pr;
    if (fire) exp_syn = ns;
    @(negedge clk);
    acc_valid = 1'b0; acc_tmiss = 1'b0; acc_prot = 1'b0;
    chk({tag, " R8 exc_req"}, 32'(exc_req), 32'(fire));
    chk({tag, " R8 exc_vec"}, 32'(exc_vec), fire ? 32'h300 : 0);
    chk({tag, " R5 bkpt bit"}, 32'(synd_q[22]), 32'(exp_syn[22]));
    chk({tag, " R6 dir bit"}, 32'(synd_q[25]), 32'(exp_syn[25]));
    chk({tag, " R7 miss/prot bits"}, {30'd0, synd_q[30], synd_q[27]},
        {30'd0, exp_syn[30], exp_syn[27]});
    chk({tag, " R9 syndrome word"}, synd_q, exp_syn);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  localparam logic [31:0] A = 32'h1234_5670;
  localparam logic [31:0] B = 32'hCAFE_0008;

  initial begin
    bp_m[0] = '0; bp_m[1] = '0; exp_syn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset syndrome", synd_q, 0);
    chk("R1 reset request", 32'(exc_req), 0);
    // R1: registers empty -> address 0 in both directions is no hit
    access(32'h0, 1'b0, 1'b0, 1'b0, "R1 empty bp load");
    access(32'h4, 1'b1, 1'b0, 1'b0, "R1 empty bp store");

    // directed R2/R3/R4
    wr_cfg(0, A | 32'h1);          // read-only on A
    wr_cfg(1, B | 32'h2);          // write-only on B
    access(A + 7, 1'b0, 1'b0, 1'b0, "R2 low bits ignored");
    access(A + 8, 1'b0, 1'b0, 1'b0, "R2 next doubleword");
    access(B + 2, 1'b1, 1'b0, 1'b0, "R3 second register");
    access(A, 1'b1, 1'b0, 1'b0, "R4 store on read-only");
    access(B, 1'b0, 1'b0, 1'b0, "R4 load on write-only");

    // R9: flags present but strobe low -> no exception, syndrome holds
    @(negedge clk);
    acc_addr = A; acc_tmiss = 1'b1; acc_prot = 1'b1;
    @(negedge clk);
    chk("R9 no strobe no request", 32'(exc_req), 0);
    chk("R9 no strobe syndrome holds", synd_q, exp_syn);
    acc_tmiss = 1'b0; acc_prot = 1'b0;

    // R10: software write, then collision with a faulting access
    wr_cfg(2, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R10 masked syndrome write", synd_q, 32'h4A40_0000);
    wr_cfg(2, 32'h0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2; cfg_wdata = 32'hFFFF_FFFF;
    acc_valid = 1'b1; acc_addr = 32'h9000_0000; acc_store = 1'b0; acc_prot = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0; acc_prot = 1'b0;
    exp_syn = 32'h0800_0000;
    chk("R10 exception wins over write", synd_q, exp_syn);

    // sweep: all enable combinations, offsets, directions, flags
    for (int en = 0; en < 16; en++) begin
      wr_cfg(0, A | 32'(en & 3));
      wr_cfg(1, B | 32'(en >> 2));
      for (int k = 0; k < 12; k++) begin
        for (int f = 0; f < 8; f++) begin
          logic [31:0] a;
          a = (k < 10) ? A + 32'(k) : ((k == 10) ? B + 3 : B + 8);
          access(a, f[0], f[1], f[2], "sweep");
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule